// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one timer channel with a small memory-mapped register window. Software programs a start value and a control word. Once enabled, the channel decrements a counter on each pulse of the chosen tick-enable input. When a tick arrives with the counter already at zero, the channel underflows. It then either restarts from the stored start value or wraps to all ones, and it raises a level interrupt that stays up until software writes to the acknowledge register.

Two single-cycle tick-enable inputs, one fast and one slow, are produced outside the block. A control bit picks which of them drives the counter. The counter width is a parameter, so the same RTL builds both narrow 16-bit channels and wide 32-bit channels. Reads are combinational from a 32-bit data bus, and all values are zero-extended to that width.

Top module: `cdt_channel`

## Requirements
- R1: After reset, the start value, the count, the control word and the pending flag are all zero, and `irq` is low.
- R2: A write to offset 0x0 stores the low counter-width bits of the data as the start value. Reading 0x0 returns that value zero-extended. On the same clock edge, the count takes the written value.
- R3: Control bit 7 is the enable. While it is 0, the count does not change on any tick.
- R4: Control bit 3 selects the tick source. When it is 1, only `tick_fast` advances the count. When it is 0, only `tick_slow` advances the count. The tick that is not selected has no effect.
- R5: Each selected tick that arrives while the channel is enabled and the count is non-zero lowers the count by exactly one.
- R6: With control bit 6 at 1 (periodic), a selected tick at count zero reloads the start value. A start value of N therefore gives a period of N+1 ticks.
- R7: With control bit 6 at 0 (free-running), a selected tick at count zero wraps the count to all ones.
- R8: Every underflow sets the pending flag on that edge. `irq` equals the pending flag and stays high until it is acknowledged.
- R9: A write of any data to offset 0xC clears the pending flag. If an underflow happens on the same edge, the flag stays set.
- R10: Reading offset 0x4 returns the live count, zero-extended. Writes to 0x4 change nothing.
- R11: If a write to 0x0 and a selected tick fall on the same edge, the written value wins, and no underflow is recorded.
- R12: Reading 0x8 returns only bits 7, 6 and 3 of the last control write, with all other bits zero. Reading 0xC or any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Fast tick enable, one cycle per tick |
| tick_slow | input | 1 | Slow tick enable, one cycle per tick |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 4 | Byte offset inside the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, high while an underflow is pending |

## Verification
The bench targets the zero-count tick, because that is where the two modes split. A design that reloads too early would give N ticks per period instead of N+1. A design that ignored the mode bit would wrap when it should reload, or reload when it should wrap.

The bench also collides events on a single edge:
- **Acknowledge with underflow.** A design where the clear wins would lose an interrupt.
- **Start-value write with tick.** A design where the tick wins would start the period one count short, or raise an interrupt that should not happen.

Unselected ticks, writes to the count register and disabled periods are all checked through the readback, so a decode or mux slip shows up as a count that moved.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_START = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 4'hC;

  localparam int unsigned BIT_RUN  = 7;
  localparam int unsigned BIT_AUTO = 6;
  localparam int unsigned BIT_FAST = 3;

  typedef struct packed {
    logic run;
    logic auto_reload;
    logic fast_sel;
  } ctrl_t;

  function automatic ctrl_t word_to_ctrl(input logic [BUS_W-1:0] w);
    ctrl_t c;
    c.run         = w[BIT_RUN];
    c.auto_reload = w[BIT_AUTO];
    c.fast_sel    = w[BIT_FAST];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [BUS_W-1:0] w;
    w = '0;
    w[BIT_RUN]  = c.run;
    w[BIT_AUTO] = c.auto_reload;
    w[BIT_FAST] = c.fast_sel;
    return w;
  endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  start_q,
  output ctrl_t             ctrl_q,
  output logic              start_wr,
  output logic              ack_wr,
  output logic [CNT_W-1:0]  start_val,
  output logic [BUS_W-1:0]  bus_rdata
);
  function automatic logic [BUS_W-1:0] widen(input logic [CNT_W-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[CNT_W-1:0] = v;
    return r;
  endfunction

  logic ctrl_wr;

  assign start_wr  = bus_wr && (bus_addr == OFS_START);
  assign ctrl_wr   = bus_wr && (bus_addr == OFS_CTRL);
  assign ack_wr    = bus_wr && (bus_addr == OFS_ACK);
  assign start_val = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (start_wr) start_q <= start_val;
      if (ctrl_wr)  ctrl_q  <= word_to_ctrl(bus_wdata);
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_START: bus_rdata = widen(start_q);
      OFS_COUNT: bus_rdata = widen(count);
      OFS_CTRL:  bus_rdata = ctrl_to_word(ctrl_q);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  ctrl_t            ctrl,
  input  logic             start_wr,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] count_q,
  output logic             step,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] after_tick(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] start,
    input logic             auto_reload
  );
    if (cur != '0) return cur - 1'b1;
    return auto_reload ? start : ALL_ONES;
  endfunction

  logic tick_sel;

  assign tick_sel  = ctrl.fast_sel ? tick_fast : tick_slow;
  assign step      = ctrl.run && tick_sel;
  assign underflow = step && !start_wr && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (start_wr) count_q <= start_val;
    else if (step)     count_q <= after_tick(count_q, start_q, ctrl.auto_reload);
  end
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic underflow,
  input  logic ack_wr,
  output logic pending_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending_q <= 1'b0;
    else if (underflow) pending_q <= 1'b1;
    else if (ack_wr)    pending_q <= 1'b0;
  end
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] start_val;
  ctrl_t            ctrl_q;
  logic             start_wr;
  logic             ack_wr;
  logic             step;
  logic             underflow;

  generate
    if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_width
      initial $error("cdt_channel: CNT_W out of range");
    end
  endgenerate

  cdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count     (count_q),
    .start_q   (start_q),
    .ctrl_q    (ctrl_q),
    .start_wr  (start_wr),
    .ack_wr    (ack_wr),
    .start_val (start_val),
    .bus_rdata (bus_rdata)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .ctrl      (ctrl_q),
    .start_wr  (start_wr),
    .start_val (start_val),
    .start_q   (start_q),
    .count_q   (count_q),
    .step      (step),
    .underflow (underflow)
  );

  cdt_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .underflow (underflow),
    .ack_wr    (ack_wr),
    .pending_q (irq)
  );
endmodule

// File: rtl/cdt_checks.sv
module cdt_checks #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] start_q,
  input logic [CNT_W-1:0] start_val,
  input logic             start_wr,
  input logic             ack_wr,
  input logic             step,
  input logic             underflow,
  input logic             auto_reload,
  input logic             irq
);
  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> count_q == $past(start_val));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !start_wr) |=> $stable(count_q));

  assert_dec_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start_wr && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && auto_reload) |=> count_q == $past(start_q));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !auto_reload) |=> count_q == {CNT_W{1'b1}});

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_wr) |=> irq);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !underflow) |=> !irq);

  assert_no_uf_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |-> !underflow);
endmodule

bind cdt_channel cdt_checks #(.CNT_W(CNT_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .count_q     (count_q),
  .start_q     (start_q),
  .start_val   (start_val),
  .start_wr    (start_wr),
  .ack_wr      (ack_wr),
  .step        (step),
  .underflow   (underflow),
  .auto_reload (ctrl_q.auto_reload),
  .irq         (irq)
);

// File: tb/cdt_channel_tb.sv
`timescale 1ns/1ps
module cdt_channel_tb;
  localparam int W = 16;
  localparam longint MASK = (64'd1 << W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0, tick_slow = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  longint m_start = 0, m_count = 0;
  bit m_run = 0, m_auto = 0, m_fast = 0, m_pend = 0;

  always #10 clk = ~clk;

  cdt_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic longint model_read(input logic [3:0] a);
    case (a)
      4'h0: return m_start;
      4'h4: return m_count;
      4'h8: return (longint'(m_run) << 7) | (longint'(m_auto) << 6) | (longint'(m_fast) << 3);
      default: return 0;
    endcase
  endfunction

  task automatic check(input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit tk, stp, swr, uf;
    tk  = m_fast ? tick_fast : tick_slow;
    stp = m_run && tk;
    swr = bus_wr && bus_addr == 4'h0;
    uf  = stp && !swr && m_count == 0;
    if (swr) begin
      m_start = bus_wdata & MASK;
      m_count = m_start;
    end else if (stp) begin
      if (m_count != 0) m_count = m_count - 1;
      else m_count = m_auto ? m_start : MASK;
    end
    if (uf) m_pend = 1;
    else if (bus_wr && bus_addr == 4'hC) m_pend = 0;
    if (bus_wr && bus_addr == 4'h8) begin
      m_run = bus_wdata[7]; m_auto = bus_wdata[6]; m_fast = bus_wdata[3];
    end
  endtask

  // drive at negedge, compare before the edge, advance model at the edge
  task automatic cyc(input bit wr, input logic [3:0] a, input logic [31:0] d,
                     input bit tf, input bit ts);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; tick_fast = tf; tick_slow = ts;
    #1;
    check($sformatf("rdata@%0h", a), bus_rdata, model_read(a));
    check("irq", irq, m_pend);
    @(posedge clk);
    model_edge();
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    cyc(1, a, d, 0, 0);
  endtask

  task automatic peek(input logic [3:0] a);
    cyc(0, a, 0, 0, 0);
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cur_req = "R1";
    peek(4'h0); peek(4'h4); peek(4'h8); peek(4'hC);
    check("R1 count zero", bus_rdata, 0);

    cur_req = "R2";
    wr_reg(4'h0, 32'hABCD0005);
    peek(4'h0); peek(4'h4);

    cur_req = "R10";
    wr_reg(4'h4, 32'h1234);
    peek(4'h4);

    cur_req = "R3";
    for (int i = 0; i < 4; i++) cyc(0, 4'h4, 0, 1, 1);

    cur_req = "R12";
    wr_reg(4'h8, 32'hFFFF_FFFF);
    peek(4'h8); peek(4'hC); peek(4'h2);
    wr_reg(4'h8, 32'h0000_00C8);

    cur_req = "R4";
    for (int i = 0; i < 3; i++) cyc(0, 4'h4, 0, 0, 1);

    cur_req = "R5";
    for (int i = 0; i < 5; i++) cyc(0, 4'h4, 0, 1, 0);

    cur_req = "R6";
    cyc(0, 4'h4, 0, 1, 0);
    check("R6 reloaded to 5", m_count, 5);
    cur_req = "R8";
    for (int i = 0; i < 3; i++) cyc(0, 4'h4, 0, 1, 0);
    peek(4'h4);

    cur_req = "R9";
    wr_reg(4'hC, 32'h0);
    peek(4'h4);

    cur_req = "R7";
    wr_reg(4'h8, 32'h0000_0080);
    wr_reg(4'h0, 32'h1);
    for (int i = 0; i < 3; i++) cyc(0, 4'h4, 0, 0, 1);
    check("R7 wrapped", m_count, MASK - 1);
    wr_reg(4'hC, 32'h5A5A);

    cur_req = "R9";
    wr_reg(4'h8, 32'h0000_00C8);
    wr_reg(4'h0, 32'h0);
    cyc(1, 4'hC, 32'h1, 1, 0);
    peek(4'h4);

    cur_req = "R11";
    wr_reg(4'hC, 32'h0);
    cyc(1, 4'h0, 32'h7, 1, 0);
    peek(4'h4);
    wr_reg(4'h0, 32'h0);
    cyc(1, 4'h0, 32'h3, 1, 0);
    peek(4'h4);

    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [3:0] a;
      r = $urandom_range(0, 19);
      a = 4'($urandom_range(0, 3) * 4);
      if (r == 0)      cyc(1, 4'h0, $urandom_range(0, 9), $urandom_range(0,1), $urandom_range(0,1));
      else if (r == 1) cyc(1, 4'h8, $urandom, $urandom_range(0,1), $urandom_range(0,1));
      else if (r == 2) cyc(1, 4'hC, $urandom, $urandom_range(0,1), $urandom_range(0,1));
      else if (r == 3) cyc(1, 4'h4, $urandom, $urandom_range(0,1), $urandom_range(0,1));
      else             cyc(0, a, 0, $urandom_range(0,1), $urandom_range(0,1));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule